// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps network time of day as a 32-bit seconds count and a 32-bit nanoseconds count. The nanoseconds count never reaches one billion. Time moves by a fixed sub-second step, 20 ns by default, but only on clocks where a 32-bit phase accumulator carries out. Each clock adds a frequency word to that accumulator. Software trims the rate of the clock by changing this word. With a 125 MHz clock, the reset word 0x66666666 gives an average of 50 million steps per second.

Software reaches the block through a plain strobe-based register port. It can stage a new frequency word and load it, set the time to an absolute value, or add or subtract an offset. A subtraction is written as complement values plus a direction flag. Each action is started by a command bit in the control register. The bit clears itself once the action has been applied. The current time is also driven as registered outputs, so that neighbouring timestamp logic can sample it.

Top module: `ptp_time_counter`

Register map (word address on `addr`):
- 0 control: bit 0 run enable (read/write); bit 2 load time, bit 3 apply offset, bit 5 load frequency word (write 1 to start, read 1 while pending).
- 1 staged frequency word.
- 2 seconds operand.
- 3 nanoseconds operand: bits 30:0 magnitude, bit 31 selects subtraction.
- 4 seconds read (returns the snapshot).
- 5 nanoseconds read (snapshots the seconds).

## Requirements
- R1: After reset, seconds and nanoseconds are 0 and the run enable is 0. The active and staged frequency words are both (TICK_HZ·2^32)/CLK_HZ, which is 0x66666666 by default.
- R2: On each clock with run enable set, the active word is added modulo 2^32 to the accumulator. Nanoseconds grow by SUBNS_INC only on a clock where that addition carries out.
- R3: When a step would bring nanoseconds to 1,000,000,000 or more, nanoseconds wrap by that amount and seconds grow by one. Nanoseconds stay below 1,000,000,000.
- R4: While run enable is 0, seconds, nanoseconds and the accumulator hold their values, except when a command is applied.
- R5: Writing 1 to control bit 5 copies the staged frequency word into the active word on the following clock.
- R6: Writing 1 to control bit 2 loads seconds from the seconds operand and nanoseconds from bits 30:0 of the nanoseconds operand on the following clock. This command takes priority over bit 3 and over a step.
- R7: Writing 1 to control bit 3 with operand bit 31 clear adds the operands to the time. A nanoseconds sum of one billion or more carries into seconds.
- R8: With operand bit 31 set, bit 3 subtracts S seconds and N ns. The operands are written as seconds = 2^32−S (0 when S is 0) and nanoseconds = 10^9−N, and a borrow from seconds is applied when N exceeds the current nanoseconds.
- R9: Command bits clear themselves one clock after they are written. A later read of control shows them as 0.
- R10: Reading address 5 returns nanoseconds and, in the same clock, snapshots seconds. Reading address 4 returns that snapshot, so the two reads give a consistent pair.
- R11: Addresses 1 to 3 read back the last value written. Read data is registered and appears one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the time base |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| sec_o | output | 32 | Current seconds |
| ns_o | output | 32 | Current nanoseconds |

## Verification
The counter is tried with frequency words that tick on roughly 40% of clocks, never, and on nearly every clock. These show that only accumulator carries move the time and that a loaded word takes effect. Initial values just below one billion force the nanoseconds wrap. Offsets are applied with the counter halted so the results can be stated exactly: an add with carry, a subtract with and without borrow, and a subtract of zero that must change nothing. These separate a correct borrow from an off-by-one-second error. Paired reads taken while the counter runs fast show whether the seconds snapshot is taken in the same clock as the nanoseconds read.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;

  localparam int CTL_RUN    = 0;
  localparam int CTL_INIT   = 2;
  localparam int CTL_UPDATE = 3;
  localparam int CTL_FREQ   = 5;
  localparam int OPND_SUB   = 31;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL    = 3'd0,
    RA_FREQ    = 3'd1,
    RA_SEC_OP  = 3'd2,
    RA_NS_OP   = 3'd3,
    RA_SEC_RD  = 3'd4,
    RA_NS_RD   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/ptp_phase_acc.sv
module ptp_phase_acc #(
  parameter int ACC_W = 32,
  parameter logic [ACC_W-1:0] RESET_WORD = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [ACC_W-1:0] staged,
  output logic             step
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] word_q;
  logic [ACC_W:0]   sum;

  assign sum  = {1'b0, acc_q} + {1'b0, word_q};
  assign step = run & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      word_q <= RESET_WORD;
    end else begin
      if (run)  acc_q  <= sum[ACC_W-1:0];
      if (load) word_q <= staged;
    end
  end
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_time_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 32,
  parameter int SUBNS_INC = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             do_init,
  input  logic             do_update,
  input  logic             subtract,
  input  logic [SEC_W-1:0] sec_op,
  input  logic [NS_W-2:0]  ns_op,
  output logic [SEC_W-1:0] sec_q,
  output logic [NS_W-1:0]  ns_q
);
  localparam logic [NS_W:0] NS_WIDE = (NS_W+1)'(NS_PER_SEC);

  logic [NS_W-1:0]  ns_step;
  logic             step_wrap;
  logic [NS_W:0]    ns_sum;
  logic             sum_wrap;
  logic [NS_W-1:0]  ns_res;
  logic [SEC_W-1:0] sec_res;

  always_comb begin
    ns_step   = ns_q + NS_W'(SUBNS_INC);
    step_wrap = ns_step >= NS_W'(NS_PER_SEC);
    ns_sum    = {1'b0, ns_q} + (NS_W+1)'(ns_op);
    sum_wrap  = ns_sum >= NS_WIDE;
    ns_res    = sum_wrap ? NS_W'(ns_sum - NS_WIDE) : NS_W'(ns_sum);
    // complement operands borrow one second unless the nanoseconds carry
    sec_res   = sec_q + sec_op + SEC_W'(sum_wrap) - SEC_W'(subtract);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (do_init) begin
      sec_q <= sec_op;
      ns_q  <= {1'b0, ns_op};
    end else if (do_update) begin
      sec_q <= sec_res;
      ns_q  <= ns_res;
    end else if (step) begin
      ns_q  <= step_wrap ? ns_step - NS_W'(NS_PER_SEC) : ns_step;
      if (step_wrap) sec_q <= sec_q + 1'b1;
    end
  end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_time_pkg::*;
#(
  parameter longint CLK_HZ    = 125_000_000,
  parameter longint TICK_HZ   = 50_000_000,
  parameter int     SUBNS_INC = 20,
  parameter int     ACC_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [31:0]       sec_o,
  output logic [31:0]       ns_o
);
  localparam logic [ACC_W-1:0] RESET_WORD = ACC_W'((TICK_HZ << ACC_W) / CLK_HZ);

  logic              run_q, init_p, upd_p, freq_p;
  logic [ACC_W-1:0]  staged_q;
  logic [31:0]       sec_op_q, ns_op_q, snap_q;
  logic              step;
  logic              wr_ctrl;

  assign wr_ctrl = wr_en && (addr == RA_CTRL);

  ptp_phase_acc #(.ACC_W(ACC_W), .RESET_WORD(RESET_WORD)) u_acc (
    .clk(clk), .rst(rst), .run(run_q), .load(freq_p),
    .staged(staged_q), .step(step)
  );

  ptp_tod_core #(.SEC_W(32), .NS_W(32), .SUBNS_INC(SUBNS_INC)) u_core (
    .clk(clk), .rst(rst), .step(step), .do_init(init_p), .do_update(upd_p),
    .subtract(ns_op_q[OPND_SUB]), .sec_op(sec_op_q), .ns_op(ns_op_q[30:0]),
    .sec_q(sec_o), .ns_q(ns_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      init_p   <= 1'b0;
      upd_p    <= 1'b0;
      freq_p   <= 1'b0;
      staged_q <= RESET_WORD;
      sec_op_q <= '0;
      ns_op_q  <= '0;
      snap_q   <= '0;
      rdata    <= '0;
    end else begin
      init_p <= wr_ctrl && wdata[CTL_INIT];
      upd_p  <= wr_ctrl && wdata[CTL_UPDATE];
      freq_p <= wr_ctrl && wdata[CTL_FREQ];
      if (wr_ctrl) run_q <= wdata[CTL_RUN];
      if (wr_en && addr == RA_FREQ)   staged_q <= wdata[ACC_W-1:0];
      if (wr_en && addr == RA_SEC_OP) sec_op_q <= wdata;
      if (wr_en && addr == RA_NS_OP)  ns_op_q  <= wdata;
      if (rd_en) begin
        case (addr)
          RA_CTRL:   rdata <= DATA_W'({freq_p, 1'b0, upd_p, init_p, 1'b0, run_q});
          RA_FREQ:   rdata <= DATA_W'(staged_q);
          RA_SEC_OP: rdata <= sec_op_q;
          RA_NS_OP:  rdata <= ns_op_q;
          RA_SEC_RD: rdata <= snap_q;
          RA_NS_RD: begin
            rdata  <= ns_o;
            snap_q <= sec_o;
          end
          default:   rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk
  import ptp_time_pkg::*;
#(
  parameter int SUBNS_INC = 20,
  parameter int ACC_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              run_q,
  input logic              init_p,
  input logic              upd_p,
  input logic              freq_p,
  input logic [ACC_W-1:0]  staged_q,
  input logic [31:0]       sec_op_q,
  input logic [31:0]       ns_op_q,
  input logic [31:0]       sec_o,
  input logic [31:0]       ns_o
);
  logic quiet;
  assign quiet = !init_p && !upd_p;

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run_q && quiet) |=> ($stable(ns_o) && $stable(sec_o))); // R4

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
    (run_q && quiet) |=> (ns_o == $past(ns_o) ||
      (ns_o == $past(ns_o) + SUBNS_INC && sec_o == $past(sec_o)) ||
      (ns_o == $past(ns_o) + SUBNS_INC - NS_PER_SEC && sec_o == $past(sec_o) + 1))); // R2

  AST_NS_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (quiet && ns_o < NS_PER_SEC) |=> (ns_o < NS_PER_SEC)); // R3

  AST_INIT_LOADS: assert property (@(posedge clk) disable iff (rst)
    init_p |=> (sec_o == $past(sec_op_q) && ns_o == {1'b0, $past(ns_op_q[30:0])})); // R6

  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((init_p || upd_p || freq_p) && !(wr_en && addr == RA_CTRL)) |=>
      !(init_p || upd_p || freq_p)); // R9

  AST_FREQ_STAGE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (freq_p && !(wr_en && addr == RA_FREQ)) |=> $stable(staged_q)); // R5
endmodule

bind ptp_time_counter ptp_time_counter_chk #(.SUBNS_INC(SUBNS_INC), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .run_q(run_q), .init_p(init_p), .upd_p(upd_p), .freq_p(freq_p),
  .staged_q(staged_q), .sec_op_q(sec_op_q), .ns_op_q(ns_op_q),
  .sec_o(sec_o), .ns_o(ns_o)
);

// File: tb/ptp_time_counter_test.sv
module ptp_time_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam longint BILLION = 1_000_000_000;
  localparam longint TWO32 = 64'h1_0000_0000;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata, sec_o, ns_o;

  ptp_time_counter uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sec_o(sec_o), .ns_o(ns_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  string phase = "R1";
  bit finished = 0;

  // behavioural reference
  longint m_sec, m_ns, m_acc, m_word, m_staged, m_secop, m_nsop, m_snap, m_rdata;
  bit m_run, m_init, m_upd, m_freq;

  always @(posedge clk) begin
    longint tot, s, n, nsec, nns, nacc, nrd, nsnap;
    bit carry;
    if (rst) begin
      m_sec = 0; m_ns = 0; m_acc = 0; m_word = (64'd50_000_000 << 32) / 64'd125_000_000;
      m_staged = m_word; m_secop = 0; m_nsop = 0; m_snap = 0; m_rdata = 0;
      m_run = 0; m_init = 0; m_upd = 0; m_freq = 0;
    end else begin
      nrd = m_rdata; nsnap = m_snap;
      if (rd_en) begin
        case (addr)
          0: nrd = (m_freq ? 32 : 0) + (m_upd ? 8 : 0) + (m_init ? 4 : 0) + (m_run ? 1 : 0);
          1: nrd = m_staged;
          2: nrd = m_secop;
          3: nrd = m_nsop;
          4: nrd = m_snap;
          5: begin nrd = m_ns; nsnap = m_sec; end
          default: nrd = 0;
        endcase
      end
      carry = m_run && (m_acc + m_word >= TWO32);
      nsec = m_sec; nns = m_ns;
      if (m_init) begin
        nsec = m_secop; nns = m_nsop % 64'h8000_0000;
      end else if (m_upd) begin
        if (m_nsop >= 64'h8000_0000) begin
          s = (m_secop == 0) ? 0 : TWO32 - m_secop;
          n = BILLION - (m_nsop - 64'h8000_0000);
          tot = m_sec * BILLION + m_ns - s * BILLION - n;
          if (tot < 0) tot = tot + TWO32 * BILLION;
        end else tot = m_sec * BILLION + m_ns + m_secop * BILLION + m_nsop;
        nsec = (tot / BILLION) % TWO32; nns = tot % BILLION;
      end else if (carry) begin
        nns = m_ns + 20;
        if (nns >= BILLION) begin nns = nns - BILLION; nsec = (m_sec + 1) % TWO32; end
      end
      nacc = m_run ? (m_acc + m_word) % TWO32 : m_acc;
      if (m_freq) m_word = m_staged;
      m_sec = nsec; m_ns = nns; m_acc = nacc; m_rdata = nrd; m_snap = nsnap;
      m_init = wr_en && addr == 0 && wdata[2];
      m_upd  = wr_en && addr == 0 && wdata[3];
      m_freq = wr_en && addr == 0 && wdata[5];
      if (wr_en && addr == 0) m_run = wdata[0];
      if (wr_en && addr == 1) m_staged = wdata;
      if (wr_en && addr == 2) m_secop = wdata;
      if (wr_en && addr == 3) m_nsop = wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      compared++;
      if (sec_o != m_sec[31:0] || ns_o != m_ns[31:0] || rdata != m_rdata[31:0]) begin
        mismatched++;
        $display("FAIL %s per-clock: sec=%0d/%0d ns=%0d/%0d rdata=%h/%h (actual/expected)",
                 phase, sec_o, m_sec, ns_o, m_ns, rdata, m_rdata[31:0]);
      end
    end
  end

  task automatic spot(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1 wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); #1 rd_en = 1; addr = a;
    @(negedge clk); v = rdata; #1 rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog expired, all requirements unfinished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    logic [31:0] hold_s, hold_n;
    repeat (3) @(negedge clk);
    #1 rst = 0;
    idle(1);
    phase = "R1";
    spot(sec_o == 0 && ns_o == 0, "R1 time after reset", ns_o, 0);
    rd(3'd1, v); spot(v == 32'h6666_6666, "R1 reset word", v, 32'h6666_6666);
    rd(3'd0, v); spot(v == 0, "R1 control after reset", v, 0);

    phase = "R2";
    wr(3'd0, 32'h1);
    idle(60);
    spot(ns_o % 20 == 0 && ns_o > 0, "R2 step multiple of increment", ns_o, 20);

    phase = "R5";
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h21);
    idle(2);
    hold_n = ns_o;
    idle(25);
    spot(ns_o == hold_n, "R5 zero word never steps", ns_o, hold_n);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 32'h21);
    idle(2);

    phase = "R6";
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd999_999_900);
    wr(3'd0, 32'h05);
    idle(1);
    phase = "R3";
    idle(25);
    spot(sec_o == 6, "R3 nanoseconds carry into seconds", sec_o, 6);
    spot(ns_o < BILLION, "R3 nanoseconds below one billion", ns_o, 0);

    phase = "R4";
    wr(3'd0, 32'h0);
    idle(2);
    hold_s = sec_o; hold_n = ns_o;
    idle(30);
    spot(sec_o == hold_s && ns_o == hold_n, "R4 stopped time holds", ns_o, hold_n);

    phase = "R6";
    wr(3'd2, 32'd10);
    wr(3'd3, 32'd100);
    wr(3'd0, 32'h04);
    idle(2);
    spot(sec_o == 10 && ns_o == 100, "R6 absolute load", ns_o, 100);

    phase = "R9";
    rd(3'd0, v);
    spot(v == 0, "R9 command bits cleared", v, 0);

    phase = "R8";
    wr(3'd2, 32'hFFFF_FFFE);
    wr(3'd3, 32'h8000_0000 | (32'd1_000_000_000 - 32'd500));
    wr(3'd0, 32'h08);
    idle(2);
    spot(sec_o == 7 && ns_o == 999_999_600, "R8 subtract with borrow", ns_o, 999_999_600);

    phase = "R7";
    wr(3'd2, 32'd1);
    wr(3'd3, 32'd999_999_950);
    wr(3'd0, 32'h08);
    idle(2);
    spot(sec_o == 9 && ns_o == 999_999_550, "R7 add with carry", ns_o, 999_999_550);

    phase = "R8";
    wr(3'd2, 32'd0);
    wr(3'd3, 32'h8000_0000 | 32'd1_000_000_000);
    wr(3'd0, 32'h08);
    idle(2);
    spot(sec_o == 9 && ns_o == 999_999_550, "R8 subtract zero unchanged", ns_o, 999_999_550);
    wr(3'd2, 32'hFFFF_FFFD);
    wr(3'd3, 32'h8000_0000 | (32'd1_000_000_000 - 32'd200));
    wr(3'd0, 32'h08);
    idle(2);
    spot(sec_o == 6 && ns_o == 999_999_350, "R8 subtract without borrow", ns_o, 999_999_350);

    phase = "R11";
    rd(3'd2, v); spot(v == 32'hFFFF_FFFD, "R11 seconds operand readback", v, 32'hFFFF_FFFD);
    rd(3'd3, v); spot(v == (32'h8000_0000 | 32'd999_999_800), "R11 ns operand readback", v, 32'h8000_0000 | 32'd999_999_800);

    phase = "R10";
    rd(3'd5, v); rd(3'd4, v2);
    spot(v == 999_999_350 && v2 == 6, "R10 paired read while stopped", v2, 6);
    wr(3'd0, 32'h1);
    idle(4);
    for (int k = 0; k < 6; k++) begin
      rd(3'd5, v); rd(3'd4, v2);
      spot(v < BILLION && v2 >= 6 && v2 <= 7, "R10 paired read while running", v2, 6);
    end
    idle(10);
    finish_run();
  end
endmodule